// File: doc/BRIEF.md
# VGA Planar Write Datapath

This block turns one CPU byte write in planar mode into per-plane write data and per-plane write strobes for a planar video memory. It combines the CPU byte with the read latches that hold the bytes last fetched from each plane, and with the graphics-controller settings: set/reset value and enables, rotate count and raster function, bit mask, plane map mask and write mode. The plane memory and the latch loading on reads sit outside this block.

Four planes are used by default. An extension flag widens the latch to eight planes. A second flag takes the plane mask from all eight bits of the map-mask register rather than only its low four. A third flag widens the write-mode field from two bits to three. Every strobe for one write appears in the same cycle, one clock after the request, together with the shared plane address.

Top module: `vga_plane_writer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all plane strobes are low and the plane address and data outputs are zero.
- R2: The write mode is `mode_sel[2:0]` when `ext_mode` is 1 and `{0, mode_sel[1:0]}` otherwise. Modes 4 to 7 assert no strobe.
- R3: In modes 0 and 3 the CPU byte is rotated right by `rot_func[2:0]` bit positions before any other use.
- R4: In mode 0, plane i takes 0xFF or 0x00 from `sr_value[i]` when `sr_enable[i]` is 1, and takes the rotated CPU byte when it is 0. The raster function is applied after this.
- R5: In mode 1 each strobed plane receives its own latch byte (plane i is `latch_bytes[8i+7:8i]`). The bit mask and the raster function have no effect.
- R6: In mode 2, plane i takes 0xFF if CPU bit i is 1 and 0x00 if it is 0. The raster function is then applied with the bit mask.
- R7: In mode 3 every plane takes 0xFF or 0x00 from its `sr_value` bit, and the effective mask is `bit_mask` ANDed with the rotated CPU byte.
- R8: `rot_func[4:3]` selects the raster function with mask m, source d and latch l. The code 00 gives (d&m)|(l&~m), 01 gives (d|~m)&l, 10 gives (d&m)|l and 11 gives (d&m)^l.
- R9: Plane i is strobed only if bit i of the plane mask is 1. The plane mask is `map_mask[7:0]` when `full_mask` is 1 and `map_mask[3:0]` otherwise.
- R10: A request with `wr_valid` high produces its strobes, data and address exactly one clock later, all in that same cycle. A cycle with `wr_valid` low produces no strobe in the next cycle.
- R11: When `wide_latch` is 0, planes 4 to 7 are never strobed. When it is 1, all eight planes can be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | CPU write request this cycle |
| wr_addr | input | AW | Plane address of the write |
| cpu_data | input | 8 | CPU data byte |
| latch_bytes | input | 64 | Read latches, plane i in bits [8i+7:8i] |
| sr_value | input | 8 | Set/reset value, one bit per plane |
| sr_enable | input | 8 | Set/reset enable, one bit per plane |
| rot_func | input | 8 | Rotate count [2:0], raster function [4:3] |
| bit_mask | input | 8 | Bit mask |
| map_mask | input | 8 | Plane map mask |
| mode_sel | input | 8 | Write-mode register |
| ext_mode | input | 1 | Use a three-bit write-mode field |
| full_mask | input | 1 | Use all eight map-mask bits |
| wide_latch | input | 1 | Eight planes instead of four |
| pl_we | output | 8 | Per-plane write strobes |
| pl_addr | output | AW | Plane address |
| pl_data | output | 64 | Per-plane write data, plane i in bits [8i+7:8i] |

## Verification
Every result of this block is due one clock after the request that causes it: strobes, data and address all come from one register stage. The bench drives each request just after a falling edge and lets the rising edge capture it. It then checks the outputs at the next falling edge against a behavioural model that is computed from the same inputs. Idle cycles are checked the same way, and they must show no strobe. Data is compared only for planes the model expects to be strobed.

// File: rtl/vga_plane_writer.sv
module vga_plane_writer #(
  parameter int AW = 16,
  parameter int PLANES = 8,
  parameter int NARROW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [AW-1:0]       wr_addr,
  input  logic [7:0]          cpu_data,
  input  logic [PLANES*8-1:0] latch_bytes,
  input  logic [7:0]          sr_value,
  input  logic [7:0]          sr_enable,
  input  logic [7:0]          rot_func,
  input  logic [7:0]          bit_mask,
  input  logic [7:0]          map_mask,
  input  logic [7:0]          mode_sel,
  input  logic                ext_mode,
  input  logic                full_mask,
  input  logic                wide_latch,
  output logic [PLANES-1:0]   pl_we,
  output logic [AW-1:0]       pl_addr,
  output logic [PLANES*8-1:0] pl_data
);
  localparam int HIGH = PLANES - NARROW;

  logic [2:0]          mode;
  logic [15:0]         rot2;
  logic [7:0]          rot;
  logic [7:0]          eff_mask;
  logic [PLANES-1:0]   pmask, present, nxt_we;
  logic [PLANES*8-1:0] nxt_data;

  assign mode     = ext_mode ? mode_sel[2:0] : {1'b0, mode_sel[1:0]};
  assign rot2     = {cpu_data, cpu_data} >> rot_func[2:0];
  assign rot      = rot2[7:0];
  assign eff_mask = (mode == 3'd3) ? (bit_mask & rot) : bit_mask;
  assign pmask    = full_mask ? map_mask[PLANES-1:0]
                              : {{HIGH{1'b0}}, map_mask[NARROW-1:0]};
  assign present  = wide_latch ? {PLANES{1'b1}} : {{HIGH{1'b0}}, {NARROW{1'b1}}};
  assign nxt_we   = (wr_valid && !mode[2]) ? (pmask & present) : '0;

  function automatic logic [7:0] plane_byte(
    input logic [2:0] md, input logic [1:0] fn, input logic sre, input logic srv,
    input logic cbit, input logic [7:0] r, input logic [7:0] l, input logic [7:0] m);
    logic [7:0] d;
    case (md)
      3'd0:    d = sre ? {8{srv}} : r;
      3'd2:    d = {8{cbit}};
      default: d = {8{srv}};
    endcase
    if (md == 3'd1) return l;
    case (fn)
      2'd0:    return (d & m) | (l & ~m);
      2'd1:    return (d | ~m) & l;
      2'd2:    return (d & m) | l;
      default: return (d & m) ^ l;
    endcase
  endfunction

  for (genvar i = 0; i < PLANES; i++) begin : g_plane
    assign nxt_data[i*8 +: 8] = plane_byte(mode, rot_func[4:3], sr_enable[i], sr_value[i],
                                           cpu_data[i], rot, latch_bytes[i*8 +: 8], eff_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pl_we   <= '0;
      pl_addr <= '0;
      pl_data <= '0;
    end else begin
      pl_we <= nxt_we;
      if (wr_valid) begin
        pl_addr <= wr_addr;
        pl_data <= nxt_data;
      end
    end
  end
endmodule

module vga_plane_writer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [63:0]   latch_bytes,
  input logic [7:0]    map_mask,
  input logic [7:0]    mode_sel,
  input logic          ext_mode,
  input logic          full_mask,
  input logic          wide_latch,
  input logic [7:0]    pl_we,
  input logic [AW-1:0] pl_addr,
  input logic [63:0]   pl_data
);
  logic [2:0] m;
  assign m = ext_mode ? mode_sel[2:0] : {1'b0, mode_sel[1:0]};

  assert_idle_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> pl_we == 8'h00);
  assert_addr_with_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> pl_addr == $past(wr_addr));
  assert_high_modes_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && m[2]) |=> pl_we == 8'h00);
  assert_mask_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (pl_we & ~$past(map_mask)) == 8'h00);
  assert_narrow_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !full_mask) |=> pl_we[7:4] == 4'h0);
  assert_four_planes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wide_latch) |=> pl_we[7:4] == 4'h0);
  assert_latch_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && m == 3'd1 && map_mask[0]) |=> pl_data[7:0] == $past(latch_bytes[7:0]));
endmodule

bind vga_plane_writer vga_plane_writer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .latch_bytes(latch_bytes), .map_mask(map_mask), .mode_sel(mode_sel),
  .ext_mode(ext_mode), .full_mask(full_mask), .wide_latch(wide_latch),
  .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data));

// File: tb/tb_vga_plane_writer.sv
module tb_vga_plane_writer;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] cpu_data = '0, sr_value = '0, sr_enable = '0, rot_func = '0;
  logic [7:0] bit_mask = '0, map_mask = '0, mode_sel = '0;
  logic ext_mode = 1'b0, full_mask = 1'b0, wide_latch = 1'b0;
  logic [63:0] latch_bytes = '0;
  logic [7:0] pl_we;
  logic [AW-1:0] pl_addr;
  logic [63:0] pl_data;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  logic [7:0]  exp_we;
  logic [63:0] exp_data;

  always #5 clk = ~clk;

  vga_plane_writer #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .cpu_data(cpu_data), .latch_bytes(latch_bytes), .sr_value(sr_value),
    .sr_enable(sr_enable), .rot_func(rot_func), .bit_mask(bit_mask),
    .map_mask(map_mask), .mode_sel(mode_sel), .ext_mode(ext_mode),
    .full_mask(full_mask), .wide_latch(wide_latch),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data));

  task automatic model();
    int md, nplanes, fn;
    logic [7:0] r, m, d, l, res, pm;
    md = ext_mode ? int'(mode_sel[2:0]) : int'(mode_sel[1:0]);
    nplanes = wide_latch ? 8 : 4;
    fn = int'(rot_func[4:3]);
    r = cpu_data;
    for (int k = 0; k < int'(rot_func[2:0]); k++) r = {r[0], r[7:1]};
    m = (md == 3) ? (bit_mask & r) : bit_mask;
    pm = full_mask ? map_mask : (map_mask & 8'h0F);
    exp_we = 8'h00;
    exp_data = '0;
    for (int p = 0; p < 8; p++) begin
      l = latch_bytes[p*8 +: 8];
      if (md == 0) d = sr_enable[p] ? (sr_value[p] ? 8'hFF : 8'h00) : r;
      else if (md == 2) d = cpu_data[p] ? 8'hFF : 8'h00;
      else d = sr_value[p] ? 8'hFF : 8'h00;
      if (md == 1) res = l;
      else if (fn == 0) res = (d & m) | (l & ~m);
      else if (fn == 1) res = (d | ~m) & l;
      else if (fn == 2) res = (d & m) | l;
      else res = (d & m) ^ l;
      exp_data[p*8 +: 8] = res;
      if (wr_valid && md < 4 && p < nplanes && pm[p]) exp_we[p] = 1'b1;
    end
  endtask

  task automatic step(input string tag);
    logic [AW-1:0] a;
    model();
    a = wr_addr;
    @(negedge clk);
    total++;
    if (pl_we !== exp_we) begin
      bad++;
      $display("FAIL %s strobes actual=%02h expected=%02h", tag, pl_we, exp_we);
    end
    for (int p = 0; p < 8; p++)
      if (exp_we[p] && pl_data[p*8 +: 8] !== exp_data[p*8 +: 8]) begin
        bad++;
        $display("FAIL %s plane %0d data actual=%02h expected=%02h", tag, p,
                 pl_data[p*8 +: 8], exp_data[p*8 +: 8]);
      end
    if (exp_we != 0 && pl_addr !== a) begin
      bad++;
      $display("FAIL %s addr actual=%04h expected=%04h", tag, pl_addr, a);
    end
  endtask

  task automatic wr(input string tag, input logic [2:0] md, input logic [7:0] cpu,
                    input logic [4:0] rf);
    wr_valid = 1'b1;
    mode_sel = {5'b0, md};
    cpu_data = cpu;
    rot_func = {3'b0, rf};
    wr_addr = wr_addr + 16'h0101;
    step(tag);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    latch_bytes = 64'h8877665544332211;
    repeat (3) @(negedge clk);
    total++;
    if (pl_we !== 8'h00 || pl_data !== 64'h0 || pl_addr !== '0) begin
      bad++;
      $display("FAIL R1 reset actual=%02h/%016h expected=00/0", pl_we, pl_data);
    end
    rst_n = 1'b1;
    step("R1");
    map_mask = 8'h0F; bit_mask = 8'hFF;
    wr("R4 plain", 3'd0, 8'hA5, 5'b00_000);
    wr("R3 rotate3", 3'd0, 8'h81, 5'b00_011);
    sr_enable = 8'h05; sr_value = 8'h01;
    wr("R4 setreset", 3'd0, 8'h3C, 5'b00_000);
    bit_mask = 8'hF0;
    wr("R4 masked", 3'd0, 8'h3C, 5'b00_000);
    sr_enable = 8'h00;
    wr("R8 and", 3'd2, 8'h0A, 5'b01_000);
    wr("R8 or", 3'd2, 8'h0A, 5'b10_000);
    wr("R8 xor", 3'd2, 8'h0A, 5'b11_000);
    wr("R6 expand", 3'd2, 8'h06, 5'b00_000);
    wr("R5 latch copy", 3'd1, 8'hFF, 5'b11_101);
    sr_value = 8'h09; bit_mask = 8'h3C;
    wr("R7 mode3", 3'd3, 8'hF0, 5'b00_000);
    wr("R7 mode3 rot", 3'd3, 8'hF0, 5'b00_010);
    wr("R3 mode3 xor", 3'd3, 8'h11, 5'b11_111);
    ext_mode = 1'b1;
    wr("R2 mode5", 3'd5, 8'h55, 5'b00_000);
    ext_mode = 1'b0;
    wr("R2 mode5 as 1", 3'd5, 8'h55, 5'b00_000);
    map_mask = 8'hF6;
    wr("R9 narrow mask", 3'd0, 8'h77, 5'b00_000);
    full_mask = 1'b1;
    wr("R11 four planes", 3'd0, 8'h77, 5'b00_000);
    wide_latch = 1'b1;
    latch_bytes = 64'hF0E1D2C3B4A59687;
    wr("R11 eight planes", 3'd2, 8'hC3, 5'b10_000);
    wr("R9 full mask", 3'd1, 8'h00, 5'b00_000);
    wr_valid = 1'b0;
    step("R10 idle");
    for (int n = 0; n < 400; n++) begin
      wr_valid = ($urandom % 5) != 0;
      wr_addr = 16'($urandom);
      cpu_data = 8'($urandom); latch_bytes = {$urandom, $urandom};
      sr_value = 8'($urandom); sr_enable = 8'($urandom);
      rot_func = 8'($urandom); bit_mask = 8'($urandom);
      map_mask = 8'($urandom); mode_sel = 8'($urandom);
      ext_mode = 1'($urandom); full_mask = 1'($urandom); wide_latch = 1'($urandom);
      step("R8 random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule